// File: doc/BRIEF.md
# Stack-Machine Branch and Stash Unit

This unit carries out the control-flow and stash instructions of a byte-coded stack machine. It owns the 16-bit program counter. It takes one opcode byte at a time, with its three mode bits. It fetches its operands from a neighbouring two-stack unit through a pop handshake. Return addresses or stashed bytes go back through a push handshake. When the instruction finishes, it commits the next program counter and gives a one-cycle completion pulse.

The unit handles five instructions: an unconditional jump, a conditional jump, a call that saves its return address, a stash that moves bytes from one stack to the other, and a break that halts the machine. In byte mode, jumps add a signed 8-bit offset to the address of the byte after the opcode. In short mode, they load a 16-bit absolute target. The return-mode bit swaps which stack supplies operands and which one receives pushes. The keep bit reads operands without removing them. A halted machine does nothing until a resume strobe loads a fresh program counter. Any other opcode only moves the program counter one byte forward. Instruction fetch, literals, memory and devices are handled elsewhere.

Top module: `stash_branch_unit`

## Requirements
- R1: After reset, `pc` equals parameter RESET_PC (default 0x0100), `halted` is 0, `op_ready` is 1, and neither `pop_req` nor `push_req` is asserted.
- R2: An accepted opcode whose low five bits are 0x00 sets `halted`, whatever its mode bits. It leaves `pc` unchanged and makes no pop or push. While `halted` is 1, `op_ready` is 0 and `op_valid` is ignored.
- R3: A `resume` strobe while halted clears `halted` and loads `pc` from `resume_pc` on the same edge. A `resume` strobe while running changes nothing.
- R4: Low five bits 0x0C in byte mode (bit 5 clear) pop one byte. `pc` becomes pc+1 plus that byte sign-extended to 16 bits, modulo 2^16.
- R5: With bit 5 set (short mode), the jump opcodes pop the low byte first and then the high byte. The target is taken as an absolute 16-bit address.
- R6: Low five bits 0x0D pop the offset (one byte, or two in short mode) and then one condition byte. The unit jumps as in R4/R5 when the condition is nonzero, and otherwise goes to pc+1.
- R7: Low five bits 0x0E pop a target as in R4/R5. They push pc+1 onto the opposite stack, high byte first so the low byte ends on top, and then jump.
- R8: Low five bits 0x0F move one byte (two in short mode) from the source stack to the opposite stack, keeping their order. `pc` becomes pc+1.
- R9: Stack select is encoded 0 = data, 1 = return. With bit 6 clear, pops use stack 0 and pushes use stack 1. With bit 6 set, the two are swapped.
- R10: With bit 7 set (keep), every pop is issued with `pop_keep`=1 at `pop_depth` 0, 1, 2 in order, so the operands stay on the source stack. The result on `pc` and on the pushes is the same as without keep.
- R11: Every other value of the low five bits makes no pop or push and advances `pc` by one.
- R12: `done` is high for exactly one cycle per accepted instruction. `pc` takes its new value on the same edge, and no instruction changes `pc` at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode byte is presented |
| op_code | input | 8 | Opcode: bit 7 keep, bit 6 return, bit 5 short, bits 4:0 instruction |
| op_ready | output | 1 | Unit idle and running; opcode accepted when both high |
| pop_req | output | 1 | Operand read request |
| pop_stk | output | 1 | Stack to read (0 data, 1 return) |
| pop_keep | output | 1 | Read without removal |
| pop_depth | output | 2 | Depth below top for a kept read |
| pop_ack | input | 1 | Stack unit supplies `pop_data` this cycle |
| pop_data | input | 8 | Operand byte |
| push_req | output | 1 | Push request |
| push_stk | output | 1 | Stack to push (0 data, 1 return) |
| push_data | output | 8 | Byte to push |
| push_ack | input | 1 | Stack unit takes `push_data` this cycle |
| resume | input | 1 | Restart strobe while halted |
| resume_pc | input | 16 | Program counter loaded on restart |
| pc | output | 16 | Program counter (address of the current opcode) |
| halted | output | 1 | Machine stopped by a break |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after a negative byte offset and a forward jump that wraps past 0xFFFF. A design that zero-extends the offset, or measures it from the opcode itself instead of the following byte, lands on the wrong address. Call and short stash are checked for byte order on the receiving stack, where a swapped push leaves the high byte on top. Return mode and keep mode are run against a stack model: a wrong stack select or a destructive kept read leaves the model's stack pointers off. A stalled handshake, the false branch of both conditional-jump widths, and resume pulses given both while halted and while running show up errors in the sequencer and in the restart path.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2 * BYTE_W;
    localparam int MAX_OPS = 3;
    localparam int CNT_W   = $clog2(MAX_OPS + 1);

    localparam int KEEP_BIT  = 7;
    localparam int RET_BIT   = 6;
    localparam int SHORT_BIT = 5;

    localparam logic [4:0] OP_BRK = 5'h00;
    localparam logic [4:0] OP_JMP = 5'h0C;
    localparam logic [4:0] OP_JCN = 5'h0D;
    localparam logic [4:0] OP_JSR = 5'h0E;
    localparam logic [4:0] OP_STH = 5'h0F;

    typedef enum logic [2:0] {K_OTHER, K_BRK, K_JMP, K_JCN, K_JSR, K_STH} kind_e;
    typedef enum logic [1:0] {S_IDLE, S_POP, S_PUSH} state_e;

    typedef struct packed {
        kind_e            kind;
        logic             keep;
        logic             ret;
        logic             wide;
        logic [CNT_W-1:0] n_pop;
        logic [CNT_W-1:0] n_push;
    } dec_t;

    typedef logic [MAX_OPS-1:0][BYTE_W-1:0] ops_t;

    function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] base,
                                                     input logic [BYTE_W-1:0] off);
        return base + {{(ADDR_W-BYTE_W){off[BYTE_W-1]}}, off};
    endfunction
endpackage

// File: rtl/sbu_decode.sv
module sbu_decode
    import sbu_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output dec_t              dec
);
    always_comb begin
        dec.keep   = op[KEEP_BIT];
        dec.ret    = op[RET_BIT];
        dec.wide   = op[SHORT_BIT];
        dec.kind   = K_OTHER;
        dec.n_pop  = '0;
        dec.n_push = '0;
        unique case (op[4:0])
            OP_BRK: dec.kind = K_BRK;
            OP_JMP: begin
                dec.kind  = K_JMP;
                dec.n_pop = op[SHORT_BIT] ? CNT_W'(2) : CNT_W'(1);
            end
            OP_JCN: begin
                dec.kind  = K_JCN;
                dec.n_pop = op[SHORT_BIT] ? CNT_W'(3) : CNT_W'(2);
            end
            OP_JSR: begin
                dec.kind   = K_JSR;
                dec.n_pop  = op[SHORT_BIT] ? CNT_W'(2) : CNT_W'(1);
                dec.n_push = CNT_W'(2);
            end
            OP_STH: begin
                dec.kind   = K_STH;
                dec.n_pop  = op[SHORT_BIT] ? CNT_W'(2) : CNT_W'(1);
                dec.n_push = op[SHORT_BIT] ? CNT_W'(2) : CNT_W'(1);
            end
            default: dec.kind = K_OTHER;
        endcase
    end
endmodule

// File: rtl/sbu_target.sv
module sbu_target
    import sbu_pkg::*;
(
    input  dec_t              dec,
    input  logic [ADDR_W-1:0] pc,
    input  ops_t              ops,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [ADDR_W-1:0] next_pc
);
    logic [ADDR_W-1:0] far;
    logic [BYTE_W-1:0] cond;

    always_comb begin
        ret_addr = pc + ADDR_W'(1);
        far      = dec.wide ? {ops[1], ops[0]} : rel_target(ret_addr, ops[0]);
        cond     = dec.wide ? ops[2] : ops[1];
        case (dec.kind)
            K_JMP, K_JSR: next_pc = far;
            K_JCN:        next_pc = (cond != '0) ? far : ret_addr;
            K_BRK:        next_pc = pc;
            default:      next_pc = ret_addr;
        endcase
    end
endmodule

// File: rtl/sbu_seq.sv
module sbu_seq
    import sbu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  dec_t              dec_in,
    output logic              op_ready,
    output dec_t              dec_q,
    output ops_t              ops_view,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic              pop_req,
    output logic              pop_stk,
    output logic              pop_keep,
    output logic [1:0]        pop_depth,
    input  logic              pop_ack,
    input  logic [BYTE_W-1:0] pop_data,
    output logic              push_req,
    output logic              push_stk,
    output logic [BYTE_W-1:0] push_data,
    input  logic              push_ack,
    input  logic              resume,
    input  logic [ADDR_W-1:0] resume_pc,
    output logic [ADDR_W-1:0] pc,
    output logic              halted,
    output logic              done
);
    state_e           state;
    ops_t             buf_q;
    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] qcnt;

    for (genvar i = 0; i < MAX_OPS; i++) begin : g_view
        assign ops_view[i] = (state == S_POP && pop_ack && pcnt == CNT_W'(i))
                             ? pop_data : buf_q[i];
    end

    always_comb begin
        op_ready  = (state == S_IDLE) && !halted;
        pop_req   = (state == S_POP);
        pop_stk   = dec_q.ret;
        pop_keep  = dec_q.keep;
        pop_depth = dec_q.keep ? 2'(pcnt) : 2'd0;
        push_req  = (state == S_PUSH);
        push_stk  = ~dec_q.ret;
        if (dec_q.kind == K_JSR)
            push_data = (qcnt == '0) ? ret_addr[ADDR_W-1:BYTE_W] : ret_addr[BYTE_W-1:0];
        else
            push_data = (dec_q.wide && qcnt == '0) ? buf_q[1] : buf_q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            pc     <= RESET_PC;
            halted <= 1'b0;
            done   <= 1'b0;
            pcnt   <= '0;
            qcnt   <= '0;
            buf_q  <= '0;
            dec_q  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (halted) begin
                        if (resume) begin
                            halted <= 1'b0;
                            pc     <= resume_pc;
                        end
                    end else if (op_valid) begin
                        dec_q <= dec_in;
                        pcnt  <= '0;
                        qcnt  <= '0;
                        if (dec_in.kind == K_BRK) begin
                            halted <= 1'b1;
                            done   <= 1'b1;
                        end else if (dec_in.n_pop == '0) begin
                            pc   <= pc + ADDR_W'(1);
                            done <= 1'b1;
                        end else begin
                            state <= S_POP;
                        end
                    end
                end
                S_POP: begin
                    if (pop_ack) begin
                        buf_q[pcnt] <= pop_data;
                        pcnt        <= pcnt + CNT_W'(1);
                        if (pcnt == dec_q.n_pop - CNT_W'(1)) begin
                            if (dec_q.n_push != '0) begin
                                state <= S_PUSH;
                            end else begin
                                pc    <= next_pc;
                                done  <= 1'b1;
                                state <= S_IDLE;
                            end
                        end
                    end
                end
                S_PUSH: begin
                    if (push_ack) begin
                        qcnt <= qcnt + CNT_W'(1);
                        if (qcnt == dec_q.n_push - CNT_W'(1)) begin
                            pc    <= next_pc;
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stash_branch_unit.sv
module stash_branch_unit
    import sbu_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [7:0]  op_code,
    output logic        op_ready,
    output logic        pop_req,
    output logic        pop_stk,
    output logic        pop_keep,
    output logic [1:0]  pop_depth,
    input  logic        pop_ack,
    input  logic [7:0]  pop_data,
    output logic        push_req,
    output logic        push_stk,
    output logic [7:0]  push_data,
    input  logic        push_ack,
    input  logic        resume,
    input  logic [15:0] resume_pc,
    output logic [15:0] pc,
    output logic        halted,
    output logic        done
);
    dec_t              dec_in;
    dec_t              dec_q;
    ops_t              ops_view;
    logic [ADDR_W-1:0] next_pc;
    logic [ADDR_W-1:0] ret_addr;

    sbu_decode u_dec (
        .op  (op_code),
        .dec (dec_in)
    );

    sbu_target u_tgt (
        .dec      (dec_q),
        .pc       (pc),
        .ops      (ops_view),
        .ret_addr (ret_addr),
        .next_pc  (next_pc)
    );

    sbu_seq #(.RESET_PC(RESET_PC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .dec_in    (dec_in),
        .op_ready  (op_ready),
        .dec_q     (dec_q),
        .ops_view  (ops_view),
        .next_pc   (next_pc),
        .ret_addr  (ret_addr),
        .pop_req   (pop_req),
        .pop_stk   (pop_stk),
        .pop_keep  (pop_keep),
        .pop_depth (pop_depth),
        .pop_ack   (pop_ack),
        .pop_data  (pop_data),
        .push_req  (push_req),
        .push_stk  (push_stk),
        .push_data (push_data),
        .push_ack  (push_ack),
        .resume    (resume),
        .resume_pc (resume_pc),
        .pc        (pc),
        .halted    (halted),
        .done      (done)
    );
endmodule

// File: rtl/sbu_checker.sv
module sbu_checker (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [7:0]  op_code,
    input logic        op_ready,
    input logic        pop_req,
    input logic        push_req,
    input logic        resume,
    input logic [15:0] resume_pc,
    input logic [15:0] pc,
    input logic        halted,
    input logic        done
);
    // R2: a stopped machine issues no stack traffic and accepts nothing
    p_halt_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!op_ready && !pop_req && !push_req));

    // R2: an accepted break stops the machine on the next cycle
    p_brk_halts_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_code[4:0] == 5'h00) |=> halted);

    // R3: restart clears the stop and loads the vector
    p_resume_r3: assert property (@(posedge clk) disable iff (rst)
        (halted && resume) |=> (!halted && pc == $past(resume_pc)));

    // R8: pops and pushes never overlap
    p_one_side_r8: assert property (@(posedge clk) disable iff (rst)
        !(pop_req && push_req));

    // R12: the program counter moves only at completion or restart
    p_pc_moves_r12: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc) |-> (done || $past(halted && resume)));
endmodule

bind stash_branch_unit sbu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_ready  (op_ready),
    .pop_req   (pop_req),
    .push_req  (push_req),
    .resume    (resume),
    .resume_pc (resume_pc),
    .pc        (pc),
    .halted    (halted),
    .done      (done)
);

// File: tb/stash_branch_unit_tb.sv
`timescale 1ns/1ps
module stash_branch_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic        op_ready;
    logic        pop_req, pop_stk, pop_keep;
    logic [1:0]  pop_depth;
    logic        pop_ack;
    logic [7:0]  pop_data;
    logic        push_req, push_stk;
    logic [7:0]  push_data;
    logic        push_ack;
    logic        resume = 1'b0;
    logic [15:0] resume_pc = 16'h0000;
    logic [15:0] pc;
    logic        halted, done;

    // stack model: 0 = data, 1 = return
    logic [7:0]  mem [0:1][0:15];
    logic [4:0]  sp [0:1];
    int          npop, npush;
    logic        clr = 1'b0, seed_v = 1'b0, seed_s = 1'b0;
    logic [7:0]  seed_b = 8'h00;
    logic        slow = 1'b0, tog = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    stash_branch_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_ready(op_ready),
        .pop_req(pop_req), .pop_stk(pop_stk), .pop_keep(pop_keep), .pop_depth(pop_depth),
        .pop_ack(pop_ack), .pop_data(pop_data), .push_req(push_req), .push_stk(push_stk),
        .push_data(push_data), .push_ack(push_ack), .resume(resume), .resume_pc(resume_pc),
        .pc(pc), .halted(halted), .done(done)
    );

    assign pop_ack  = pop_req && (!slow || tog);
    assign push_ack = push_req && (!slow || !tog);
    always_comb pop_data = mem[pop_stk][4'(sp[pop_stk] - 5'd1 - 5'(pop_depth))];

    always @(posedge clk) begin
        tog <= ~tog;
        if (clr) begin
            sp[0] <= 5'd0; sp[1] <= 5'd0; npop <= 0; npush <= 0;
        end else begin
            if (seed_v) begin
                mem[seed_s][4'(sp[seed_s])] <= seed_b;
                sp[seed_s] <= sp[seed_s] + 5'd1;
            end
            if (pop_req && pop_ack) begin
                npop <= npop + 1;
                if (!pop_keep) sp[pop_stk] <= sp[pop_stk] - 5'd1;
            end
            if (push_req && push_ack) begin
                npush <= npush + 1;
                mem[push_stk][4'(sp[push_stk])] <= push_data;
                sp[push_stk] <= sp[push_stk] + 5'd1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clear_stacks();
        clr = 1'b1; @(negedge clk); clr = 1'b0;
    endtask

    task automatic seed(input logic s, input logic [7:0] b);
        seed_v = 1'b1; seed_s = s; seed_b = b; @(negedge clk); seed_v = 1'b0;
    endtask

    task automatic run(input logic [7:0] op);
        bit acc;
        int guard = 0;
        op_valid = 1'b1; op_code = op;
        do begin
            acc = op_ready;
            @(negedge clk);
        end while (!acc && ++guard < 50);
        op_valid = 1'b0;
        while (!done && guard < 100) begin
            @(negedge clk); guard++;
        end
        if (!done) chk("R12 done never seen", 32'(done), 32'd1);
    endtask

    task automatic set_pc(input logic [15:0] v);
        run(8'h00);
        resume = 1'b1; resume_pc = v;
        @(negedge clk);
        resume = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pc", 32'(pc), 32'h0100);
        chk("R1 halted", 32'(halted), 32'd0);
        chk("R1 ready", 32'(op_ready), 32'd1);
        chk("R1 no requests", 32'({pop_req, push_req}), 32'd0);
    endtask

    task automatic t_jmp_byte();
        clear_stacks();
        seed(0, 8'h05); run(8'h0C);
        chk("R4 forward", 32'(pc), 32'h0106);
        @(negedge clk);
        chk("R12 done one cycle", 32'(done), 32'd0);
        seed(0, 8'hFA); run(8'h0C);
        chk("R4 backward", 32'(pc), 32'h0101);
        chk("R4 stack drained", 32'(sp[0]), 32'd0);
        set_pc(16'hFFF0);
        seed(0, 8'h20); run(8'h0C);
        chk("R4 wrap", 32'(pc), 32'h0011);
    endtask

    task automatic t_jmp_short();
        clear_stacks();
        seed(0, 8'h12); seed(0, 8'h34); run(8'h2C);
        chk("R5 absolute", 32'(pc), 32'h1234);
        chk("R5 two pops", 32'(npop), 32'd2);
    endtask

    task automatic t_jcn();
        clear_stacks();
        seed(0, 8'h00); seed(0, 8'h10); run(8'h0D);
        chk("R6 false byte", 32'(pc), 32'h1235);
        seed(0, 8'h03); seed(0, 8'h10); run(8'h0D);
        chk("R6 true byte", 32'(pc), 32'h1246);
        seed(0, 8'h01); seed(0, 8'hAB); seed(0, 8'hCD); run(8'h2D);
        chk("R6 true short", 32'(pc), 32'hABCD);
        seed(0, 8'h00); seed(0, 8'h11); seed(0, 8'h22); run(8'h2D);
        chk("R6 false short", 32'(pc), 32'hABCE);
        chk("R6 stack drained", 32'(sp[0]), 32'd0);
    endtask

    task automatic t_jsr();
        clear_stacks();
        set_pc(16'h0200);
        seed(0, 8'h04); run(8'h0E);
        chk("R7 target", 32'(pc), 32'h0205);
        chk("R7 R9 return depth", 32'(sp[1]), 32'd2);
        chk("R7 low on top", 32'(mem[1][1]), 32'h01);
        chk("R7 high below", 32'(mem[1][0]), 32'h02);
        clear_stacks();
        set_pc(16'h0300);
        seed(1, 8'h20); seed(1, 8'h00); run(8'h6E);
        chk("R9 short call target", 32'(pc), 32'h2000);
        chk("R9 data gets return", 32'({sp[0], mem[0][0], mem[0][1]}), {11'd0, 5'd2, 8'h03, 8'h01});
        chk("R9 return drained", 32'(sp[1]), 32'd0);
    endtask

    task automatic t_sth();
        logic [15:0] p0;
        clear_stacks();
        p0 = pc;
        seed(0, 8'h77); run(8'h0F);
        chk("R8 moved byte", 32'({sp[0], sp[1], mem[1][0]}), {11'd0, 5'd0, 5'd1, 8'h77});
        chk("R8 pc step", 32'(pc), 32'(p0 + 16'd1));
        clear_stacks();
        seed(1, 8'hA1); seed(1, 8'hB2); run(8'h6F);
        chk("R9 R8 short order", 32'({sp[0], sp[1], mem[0][0], mem[0][1]}),
            {6'd0, 5'd2, 5'd0, 8'hA1, 8'hB2});
    endtask

    task automatic t_keep();
        clear_stacks();
        seed(0, 8'h30); seed(0, 8'h00); run(8'hAC);
        chk("R10 kept jump target", 32'(pc), 32'h3000);
        chk("R10 operands stay", 32'({sp[0], 8'(npop)}), {19'd0, 5'd2, 8'd2});
        clear_stacks();
        seed(0, 8'h55); run(8'h8F);
        chk("R10 kept stash", 32'({sp[0], sp[1], mem[1][0]}), {11'd0, 5'd1, 5'd1, 8'h55});
        clear_stacks();
        seed(0, 8'h01); seed(0, 8'h08); run(8'h8D);
        chk("R10 kept cond jump", 32'(pc), 32'h300A);
        chk("R10 cond operands stay", 32'(sp[0]), 32'd2);
    endtask

    task automatic t_other();
        logic [15:0] p0;
        clear_stacks();
        p0 = pc;
        run(8'h18);
        chk("R11 step", 32'(pc), 32'(p0 + 16'd1));
        run(8'hE1);
        chk("R11 step with modes", 32'(pc), 32'(p0 + 16'd2));
        chk("R11 no stack traffic", 32'(npop + npush), 32'd0);
    endtask

    task automatic t_brk();
        logic [15:0] p0;
        clear_stacks();
        p0 = pc;
        run(8'h40);
        chk("R2 halted", 32'(halted), 32'd1);
        chk("R2 pc kept", 32'(pc), 32'(p0));
        op_valid = 1'b1; op_code = 8'h0C;
        repeat (5) @(negedge clk);
        chk("R2 not ready", 32'(op_ready), 32'd0);
        op_valid = 1'b0;
        chk("R2 opcode ignored", 32'({pc, 8'(npop)}), {p0, 8'd0});
        resume = 1'b1; resume_pc = 16'h4567;
        @(negedge clk);
        resume = 1'b0;
        chk("R3 restart", 32'({halted, pc}), {15'd0, 1'b0, 16'h4567});
        resume = 1'b1; resume_pc = 16'hDEAD;
        @(negedge clk);
        resume = 1'b0;
        @(negedge clk);
        chk("R3 resume ignored running", 32'({halted, pc}), {15'd0, 1'b0, 16'h4567});
    endtask

    task automatic t_slow();
        slow = 1'b1;
        clear_stacks();
        set_pc(16'h0500);
        seed(0, 8'h10); seed(0, 8'h00); run(8'h2E);
        chk("R7 stalled call target", 32'(pc), 32'h1000);
        chk("R7 stalled return bytes", 32'({mem[1][0], mem[1][1]}), 32'h0501);
        slow = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_stacks();
        t_reset();
        t_jmp_byte();
        t_jmp_short();
        t_jcn();
        t_jsr();
        t_sth();
        t_keep();
        t_other();
        t_brk();
        t_slow();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL R12 watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule